// File: doc/BRIEF.md
# Direct-Mapped Cache Controller

This block is a direct-mapped cache that sits between a processor's word request port and a memory port that moves a whole line in one transfer. It holds a data line, a tag, a valid bit and a dirty bit for each line. A request that hits finishes in the same cycle. A miss starts a line fill. Under write-back, a miss whose victim line is dirty first writes that whole line out to memory.

Parameters choose the size, the line length, the write policy and the write-miss policy. The write policy is write-through or write-back. The write-miss policy is allocate or no-allocate. An instance that is never sent stores acts as an instruction cache. An instance that gets loads and stores acts as a data cache.

The requester holds its request steady until `done` is high for one cycle, then drops the request or replaces it. The memory side answers each request with a one-cycle `mem_ack`. On a read, the line comes back on `mem_rdata` in that same cycle.

Top module: `dm_cache_ctrl`

## Requirements
- R1: After reset every line is invalid and clean. With no request, `mem_req`, `done` and `hit` are low, and the first access to any address misses.
- R2: A read hit raises `hit` and `done` in the cycle the request is presented. It returns the word on `rdata` and makes no memory request.
- R3: A read miss issues a line read (`mem_we`=0) at the address with its 5 offset bits cleared. When `mem_ack` arrives, the line is installed and the requested word is returned.
- R4: The byte address splits into bits [4:0] for the offset within the line (bits [4:2] select the word), then an index of log2(lines) bits, then the tag. Two addresses with the same index and different tags replace each other.
- R5: Under write-back, a store hit updates the word and sets the line's dirty bit. It completes in the same cycle and makes no memory request.
- R6: Under write-back, a miss whose victim line is valid and dirty raises `victim_dirty`. It then writes the victim's full line (`mem_wmask` all ones) at the victim's own address before the line read for the new address.
- R7: Under write-through, a store hit updates the cached word and issues a single-word write. That write uses a one-hot `mem_wmask` (bit = word select) at the word address and completes on `mem_ack`. Lines never become dirty, so an eviction never writes a line back.
- R8: Under no-write-allocate, a store miss only writes the word to memory, and the cache contents and tags stay unchanged.
- R9: Under write-allocate, a store miss fills the line and then writes the word into it. The rest of the line holds the memory contents.
- R10: Replacing a clean or invalid line issues only the line read, with no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present, held until done |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | WORD_W | Store data |
| done | output | 1 | Request completes this cycle |
| rdata | output | WORD_W | Load data, valid with done |
| hit | output | 1 | Lookup hit on the presented request |
| victim_dirty | output | 1 | Line to be replaced holds modified data |
| mem_req | output | 1 | Memory transfer requested |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | ADDR_W | Line address, or word address for single-word writes |
| mem_wdata | output | LINE_WORDS*WORD_W | Write data, word n in slice n |
| mem_wmask | output | LINE_WORDS | Words to be written |
| mem_ack | input | 1 | Transfer finished (one cycle) |
| mem_rdata | input | LINE_WORDS*WORD_W | Line read data, valid with mem_ack |

## Verification
The bench uses two configurations. The first is write-back with allocate. It targets a dirty line being evicted by a conflicting tag, where a design that skipped the write-back would lose the stored word; reading that word back after a second eviction exposes the loss. The second is write-through with no-allocate. A store there must write exactly one memory word and leave the neighbouring words intact, and a store miss must not disturb the line resident at that index. A wrong mask would corrupt adjacent memory words, and wrongly allocating on the store miss would turn the follow-up read hit into a miss.

// File: rtl/dm_cache_ctrl.sv
module dm_cache_ctrl #(
  parameter int ADDR_W      = 10,
  parameter int WORD_W      = 32,
  parameter int LINE_WORDS  = 8,
  parameter int CACHE_BYTES = 256,
  parameter bit WRITE_BACK  = 1'b1,
  parameter bit WRITE_ALLOC = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic                         req_write,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [WORD_W-1:0]            req_wdata,
  output logic                         done,
  output logic [WORD_W-1:0]            rdata,
  output logic                         hit,
  output logic                         victim_dirty,
  output logic                         mem_req,
  output logic                         mem_we,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [LINE_WORDS*WORD_W-1:0] mem_wdata,
  output logic [LINE_WORDS-1:0]        mem_wmask,
  input  logic                         mem_ack,
  input  logic [LINE_WORDS*WORD_W-1:0] mem_rdata
);
  localparam int LINE_W   = LINE_WORDS * WORD_W;
  localparam int BYTE_OFF = $clog2(WORD_W / 8);
  localparam int WSEL_W   = $clog2(LINE_WORDS);
  localparam int OFF_W    = BYTE_OFF + WSEL_W;
  localparam int LINES    = CACHE_BYTES / (LINE_WORDS * WORD_W / 8);
  localparam int IDX_W    = $clog2(LINES);
  localparam int TAG_W    = ADDR_W - OFF_W - IDX_W;

  typedef enum logic [1:0] {S_IDLE, S_EVICT, S_FILL, S_WORD} state_t;

  state_t            state_q, state_d;
  logic [LINE_W-1:0] data_q [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINES-1:0]  valid_q, dirty_q;

  wire [IDX_W-1:0]  idx  = req_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0]  tag  = req_addr[ADDR_W-1 -: TAG_W];
  wire [WSEL_W-1:0] wsel = req_addr[BYTE_OFF +: WSEL_W];
  wire unused_byte_bits  = ^req_addr[BYTE_OFF-1:0];

  wire lookup   = valid_q[idx] && (tag_q[idx] == tag);
  wire in_idle  = (state_q == S_IDLE) && req_valid;
  wire wr_hit   = hit && req_write;
  wire fill_ack = (state_q == S_FILL) && mem_ack;

  assign hit          = in_idle && lookup;
  assign victim_dirty = in_idle && !lookup && valid_q[idx] && dirty_q[idx]
                        && (!req_write || WRITE_ALLOC);
  assign rdata        = data_q[idx][wsel*WORD_W +: WORD_W];
  assign done         = (state_q == S_WORD) ? mem_ack : (hit && !(req_write && !WRITE_BACK));

  assign mem_req   = (state_q != S_IDLE);
  assign mem_we    = (state_q == S_EVICT) || (state_q == S_WORD);
  assign mem_wdata = (state_q == S_EVICT) ? data_q[idx] : {LINE_WORDS{req_wdata}};
  assign mem_wmask = (state_q == S_EVICT) ? {LINE_WORDS{1'b1}} :
                     (state_q == S_WORD)  ? (LINE_WORDS'(1) << wsel) : '0;

  always_comb begin
    case (state_q)
      S_EVICT: mem_addr = {tag_q[idx], idx, {OFF_W{1'b0}}};
      S_FILL:  mem_addr = {tag, idx, {OFF_W{1'b0}}};
      default: mem_addr = {req_addr[ADDR_W-1:BYTE_OFF], {BYTE_OFF{1'b0}}};
    endcase
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:
        if (in_idle) begin
          if (lookup) begin
            if (req_write && !WRITE_BACK) state_d = S_WORD;
          end else if (req_write && !WRITE_ALLOC) state_d = S_WORD;
          else if (victim_dirty)                  state_d = S_EVICT;
          else                                    state_d = S_FILL;
        end
      S_EVICT: if (mem_ack) state_d = S_FILL;
      default: if (mem_ack) state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      state_q <= state_d;
      if (fill_ack) begin
        valid_q[idx] <= 1'b1;
        dirty_q[idx] <= 1'b0;
      end else if (wr_hit && WRITE_BACK) begin
        dirty_q[idx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_ack) begin
      data_q[idx] <= mem_rdata;
      tag_q[idx]  <= tag;
    end else if (wr_hit) begin
      data_q[idx][wsel*WORD_W +: WORD_W] <= req_wdata;
    end
  end
endmodule

// File: rtl/dm_cache_ctrl_chk.sv
module dm_cache_ctrl_chk #(
  parameter int ADDR_W     = 10,
  parameter int LINE_WORDS = 8,
  parameter int OFF_W      = 5,
  parameter bit WRITE_BACK = 1'b1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_write,
  input logic                  hit,
  input logic                  victim_dirty,
  input logic                  done,
  input logic                  mem_req,
  input logic                  mem_we,
  input logic                  mem_ack,
  input logic [ADDR_W-1:0]     mem_addr,
  input logic [LINE_WORDS-1:0] mem_wmask
);
  assert_read_hit_local_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit && !req_write) |-> (done && !mem_req));

  assert_done_has_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_valid);

  assert_fill_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr[OFF_W-1:0] == '0));

  assert_evict_then_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ack && mem_we && (&mem_wmask)) |=> (mem_req && !mem_we));

  generate
    if (WRITE_BACK) begin : g_wb
      assert_store_hit_local_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && req_write) |-> (done && !mem_req));
    end else begin : g_wt
      assert_store_hit_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && req_write) |=> (mem_req && mem_we && $countones(mem_wmask) == 1));
      assert_never_dirty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !victim_dirty);
    end
  endgenerate
endmodule

bind dm_cache_ctrl dm_cache_ctrl_chk #(
  .ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS), .OFF_W(OFF_W), .WRITE_BACK(WRITE_BACK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .hit(hit), .victim_dirty(victim_dirty), .done(done), .mem_req(mem_req),
  .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_wmask(mem_wmask)
);

// File: tb/tb_dm_cache_ctrl.sv
module tb_dm_cache_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 256;

  typedef struct packed {
    logic        wr;
    logic [9:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp_rd;
    logic        chk_rd;
    logic        exp_hit;
    logic        exp_vd;
    logic [3:0]  d_brd;
    logic [3:0]  d_bwr;
    logic [3:0]  d_wwr;
  } vec_t;

  // instance 0: write-back, write-allocate, 256 B (index = addr[7:5])
  localparam vec_t VEC [10] = '{
    '{1'b0, 10'h004, 32'h0,        32'hA0000001, 1'b1, 1'b0, 1'b0, 4'd1, 4'd0, 4'd0}, // R1 R3 cold miss
    '{1'b0, 10'h01C, 32'h0,        32'hA0000007, 1'b1, 1'b1, 1'b0, 4'd0, 4'd0, 4'd0}, // R2 hit
    '{1'b1, 10'h008, 32'h11111111, 32'h0,        1'b0, 1'b1, 1'b0, 4'd0, 4'd0, 4'd0}, // R5 store hit
    '{1'b0, 10'h008, 32'h0,        32'h11111111, 1'b1, 1'b1, 1'b0, 4'd0, 4'd0, 4'd0}, // R5 readback
    '{1'b0, 10'h104, 32'h0,        32'hA0000041, 1'b1, 1'b0, 1'b1, 4'd1, 4'd1, 4'd0}, // R4 R6 dirty evict
    '{1'b0, 10'h008, 32'h0,        32'h11111111, 1'b1, 1'b0, 1'b0, 4'd1, 4'd0, 4'd0}, // R6 R10 clean evict
    '{1'b1, 10'h044, 32'h22222222, 32'h0,        1'b0, 1'b0, 1'b0, 4'd1, 4'd0, 4'd0}, // R9 allocate
    '{1'b0, 10'h044, 32'h0,        32'h22222222, 1'b1, 1'b1, 1'b0, 4'd0, 4'd0, 4'd0}, // R9
    '{1'b0, 10'h040, 32'h0,        32'hA0000010, 1'b1, 1'b1, 1'b0, 4'd0, 4'd0, 4'd0}, // R9 rest of line
    '{1'b0, 10'h3E0, 32'h0,        32'hA00000F8, 1'b1, 1'b0, 1'b0, 4'd1, 4'd0, 4'd0}  // R4 top index
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic          req_valid [2], req_write [2], done [2], hit [2], vdirty [2];
  logic          mem_req [2], mem_we [2], mem_ack [2];
  logic [9:0]    req_addr [2], mem_addr [2];
  logic [31:0]   req_wdata [2], rdata [2];
  logic [LW-1:0] mem_wdata [2], mem_rdata [2];
  logic [7:0]    mem_wmask [2];
  logic [31:0]   mem [2][256];
  int brd [2], bwr [2], wwr [2], cnt [2];
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dm_cache_ctrl #(.CACHE_BYTES(256), .WRITE_BACK(1'b1), .WRITE_ALLOC(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid[0]), .req_write(req_write[0]),
    .req_addr(req_addr[0]), .req_wdata(req_wdata[0]), .done(done[0]), .rdata(rdata[0]),
    .hit(hit[0]), .victim_dirty(vdirty[0]), .mem_req(mem_req[0]), .mem_we(mem_we[0]),
    .mem_addr(mem_addr[0]), .mem_wdata(mem_wdata[0]), .mem_wmask(mem_wmask[0]),
    .mem_ack(mem_ack[0]), .mem_rdata(mem_rdata[0]));

  dm_cache_ctrl #(.CACHE_BYTES(128), .WRITE_BACK(1'b0), .WRITE_ALLOC(1'b0)) dut_wt (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid[1]), .req_write(req_write[1]),
    .req_addr(req_addr[1]), .req_wdata(req_wdata[1]), .done(done[1]), .rdata(rdata[1]),
    .hit(hit[1]), .victim_dirty(vdirty[1]), .mem_req(mem_req[1]), .mem_we(mem_we[1]),
    .mem_addr(mem_addr[1]), .mem_wdata(mem_wdata[1]), .mem_wmask(mem_wmask[1]),
    .mem_ack(mem_ack[1]), .mem_rdata(mem_rdata[1]));

  initial begin
    for (int g = 0; g < 2; g++) begin
      for (int k = 0; k < 256; k++) mem[g][k] = (g == 0 ? 32'hA0000000 : 32'hB0000000) + k;
      brd[g] = 0; bwr[g] = 0; wwr[g] = 0; cnt[g] = 0;
      mem_ack[g] = 1'b0; mem_rdata[g] = '0;
      req_valid[g] = 1'b0; req_write[g] = 1'b0; req_addr[g] = '0; req_wdata[g] = '0;
    end
  end

  always @(posedge clk) begin
    for (int g = 0; g < 2; g++) begin
      mem_ack[g] <= 1'b0;
      if (rst_n && mem_req[g] && !mem_ack[g]) begin
        if (cnt[g] == 2) begin
          cnt[g] <= 0;
          mem_ack[g] <= 1'b1;
          if (mem_we[g]) begin
            for (int w = 0; w < 8; w++)
              if (mem_wmask[g][w]) mem[g][{mem_addr[g][9:5], 3'b000} + w] <= mem_wdata[g][w*32 +: 32];
            if (&mem_wmask[g]) bwr[g] <= bwr[g] + 1; else wwr[g] <= wwr[g] + 1;
          end else begin
            for (int w = 0; w < 8; w++) mem_rdata[g][w*32 +: 32] <= mem[g][{mem_addr[g][9:5], 3'b000} + w];
            brd[g] <= brd[g] + 1;
          end
        end else cnt[g] <= cnt[g] + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic access(input int i, input bit wr, input logic [9:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output bit h, output bit vd, output bit d0);
    @(negedge clk);
    req_valid[i] = 1'b1; req_write[i] = wr; req_addr[i] = a; req_wdata[i] = wd;
    #1;
    h = hit[i]; vd = vdirty[i]; d0 = done[i];
    while (!done[i]) begin @(negedge clk); #1; end
    rd = rdata[i];
    @(posedge clk); #1;
    req_valid[i] = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    bit h, vd, d0;
    int b0, b1, w0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    for (int g = 0; g < 2; g++) begin
      check(!mem_req[g], "R1", "idle mem_req", 32'(mem_req[g]), 0);
      check(!done[g] && !hit[g], "R1", "idle done/hit", {done[g], hit[g]}, 0);
    end

    foreach (VEC[n]) begin
      b0 = brd[0]; b1 = bwr[0]; w0 = wwr[0];
      access(0, VEC[n].wr, VEC[n].addr, VEC[n].wdata, rd, h, vd, d0);
      check(h == VEC[n].exp_hit, "R2/R3", $sformatf("vec%0d hit", n), 32'(h), 32'(VEC[n].exp_hit));
      check(vd == VEC[n].exp_vd, "R6", $sformatf("vec%0d victim_dirty", n), 32'(vd), 32'(VEC[n].exp_vd));
      if (VEC[n].chk_rd) check(rd == VEC[n].exp_rd, "R3", $sformatf("vec%0d rdata", n), rd, VEC[n].exp_rd);
      check(brd[0] - b0 == int'(VEC[n].d_brd), "R3", $sformatf("vec%0d line reads", n), brd[0] - b0, VEC[n].d_brd);
      check(bwr[0] - b1 == int'(VEC[n].d_bwr), "R6", $sformatf("vec%0d line writes", n), bwr[0] - b1, VEC[n].d_bwr);
      check(wwr[0] - w0 == int'(VEC[n].d_wwr), "R5", $sformatf("vec%0d word writes", n), wwr[0] - w0, VEC[n].d_wwr);
    end
    check(mem[0][2] == 32'h11111111, "R6", "written-back word in memory", mem[0][2], 32'h11111111);

    // write-through, no-allocate, 128 B (index = addr[6:5])
    access(1, 1'b0, 10'h010, 0, rd, h, vd, d0);
    check(!h && rd == 32'hB0000004, "R3", "wt cold read", rd, 32'hB0000004);
    w0 = wwr[1];
    access(1, 1'b1, 10'h014, 32'h33333333, rd, h, vd, d0);
    check(h && !d0, "R7", "store hit waits for memory", {h, d0}, 32'h2);
    check(wwr[1] - w0 == 1, "R7", "single word write", wwr[1] - w0, 1);
    check(mem[1][5] == 32'h33333333, "R7", "target word", mem[1][5], 32'h33333333);
    check(mem[1][4] == 32'hB0000004 && mem[1][6] == 32'hB0000006, "R7", "neighbour words", mem[1][4], 32'hB0000004);
    access(1, 1'b0, 10'h014, 0, rd, h, vd, d0);
    check(h && rd == 32'h33333333, "R7", "cache updated", rd, 32'h33333333);
    b1 = bwr[1];
    access(1, 1'b0, 10'h090, 0, rd, h, vd, d0);
    check(!vd && bwr[1] == b1, "R10", "no write-back of clean line", bwr[1] - b1, 0);
    check(rd == 32'hB0000024, "R4", "conflict line data", rd, 32'hB0000024);
    b0 = brd[1]; w0 = wwr[1];
    access(1, 1'b1, 10'h200, 32'h44444444, rd, h, vd, d0);
    check(!h && brd[1] == b0 && wwr[1] - w0 == 1, "R8", "store miss word only", brd[1] - b0, 0);
    check(mem[1][128] == 32'h44444444, "R8", "store miss memory word", mem[1][128], 32'h44444444);
    access(1, 1'b0, 10'h090, 0, rd, h, vd, d0);
    check(h && rd == 32'hB0000024, "R8", "resident line kept", {31'(0), h}, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule